// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block owns the floating-point unit's control/status word and performs the exception accounting that follows every arithmetic or conversion instruction. Software reads and writes the word through a small control-register port addressed by a 5-bit index. Only one index selects the word. The execution datapath reports each finished instruction as a single-cycle strobe, together with six condition bits that say what the instruction raised.

For each report, the unit replaces the cause field with the conditions that instruction raised. Raised conditions whose enable bit is clear are accumulated into sticky flags. Raised conditions whose enable bit is set produce a one-cycle trap request. The current rounding mode is driven out continuously for the datapath. The report strobe carries no back-pressure: it is accepted in every cycle, so no ready signal exists and the control and status pins stay plain.

Report condition bits use this encoding: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid, bit 5 unimplemented.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the whole status word is zero and no trap is requested.
- R2: A read at control index 31 returns the status word. A read at any other index returns zero.
- R3: A write at any index other than 31 leaves the status word unchanged.
- R4: Only bits 1:0, 17:2, 23 and 24 are writable. All other bit positions always read zero.
- R5: The rounding-mode output always equals bits 1:0 of the word (0 nearest, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity).
- R6: On every report, bits 17:12 are replaced by the reported conditions in report-bit order (bit 12 inexact through bit 17 unimplemented). Cause bits not raised by that report are cleared.
- R7: A report that raises underflow or overflow also sets the inexact cause, and inexact is then handled as raised.
- R8: A raised maskable condition whose enable is clear sets its flag (bits 6:2, inexact at bit 2 up to invalid at bit 6). A flag stays set until software writes it clear.
- R9: A raised maskable condition whose enable is set (bits 11:7, same order as the flags) requests a trap and does not set its flag. The trap output is high for exactly the one cycle in which the new cause value first appears.
- R10: A raised unimplemented condition always requests a trap. It has no flag and no enable.
- R11: When a write at index 31 and a report occur in the same cycle, the report is applied to the written value, using the written enables.
- R12: In a cycle with neither a write at index 31 nor a report, the status word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_wr_en_i | input | 1 | Control-register write strobe |
| ctl_wr_idx_i | input | 5 | Control-register write index |
| ctl_wr_data_i | input | 32 | Control-register write data |
| ctl_rd_idx_i | input | 5 | Control-register read index |
| ctl_rd_data_o | output | 32 | Read data (combinational) |
| rpt_valid_i | input | 1 | Instruction-completed strobe |
| rpt_cond_i | input | 6 | Conditions raised by the completed instruction |
| round_mode_o | output | 2 | Current rounding mode |
| csr_o | output | 32 | Full status word |
| trap_o | output | 1 | One-cycle trap request |

## Verification
The main sweep walks all 32 enable masks. Under each mask it issues all 64 condition patterns back to back. This separates trapping from flagging for every condition and checks that every flag stays set across later reports that do not raise it. Patterns that hold underflow or overflow without inexact show whether inexact is forced on. Patterns that carry the unimplemented bit under an all-clear mask show that this condition cannot be masked. Directed steps cover:
- reads and writes at a wrong index;
- writes of all ones, which expose the reserved positions;
- idle cycles;
- a write and a report in the same cycle, where the written enables decide between trap and flag.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int CSR_W     = 32;
  localparam int NCOND     = 6;
  localparam int NMASKABLE = 5;

  // field positions inside the status word
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = 7;
  localparam int CAUSE_LSB = 12;
  localparam int CMP_BIT   = 23;
  localparam int FTZ_BIT   = 24;

  // condition numbering shared by report bus, cause, flags and enables
  localparam int C_INEXACT = 0;
  localparam int C_UNDER   = 1;
  localparam int C_OVER    = 2;
  localparam int C_DIVZ    = 3;
  localparam int C_INVALID = 4;
  localparam int C_UNIMPL  = 5;

  localparam logic [CSR_W-1:0] FIELD_MASK =
      (CSR_W'((1 << (CAUSE_LSB + NCOND)) - 1)) |
      (CSR_W'(1) << CMP_BIT) | (CSR_W'(1) << FTZ_BIT);

  typedef logic [NCOND-1:0]     cond_t;
  typedef logic [NMASKABLE-1:0] mask_t;
endpackage

// File: rtl/fpcsr_port.sv
module fpcsr_port
  import fpcsr_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int CTL_INDEX = 31
) (
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CSR_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [CSR_W-1:0] csr_i,
  output logic             wr_hit_o,
  output logic [CSR_W-1:0] wr_val_o,
  output logic [CSR_W-1:0] rd_data_o
);
  localparam logic [IDX_W-1:0] HIT_IDX = IDX_W'(CTL_INDEX);

  assign wr_hit_o  = wr_en_i && (wr_idx_i == HIT_IDX);
  assign wr_val_o  = wr_data_i & FIELD_MASK;
  assign rd_data_o = (rd_idx_i == HIT_IDX) ? csr_i : '0;
endmodule

// File: rtl/fpcsr_event.sv
module fpcsr_event
  import fpcsr_pkg::*;
(
  input  logic  valid_i,
  input  cond_t cond_i,
  input  mask_t enable_i,
  output cond_t cause_o,
  output mask_t flag_set_o,
  output logic  trap_o
);
  cond_t norm;
  mask_t fire;

  // a range error is never exact
  always_comb begin
    norm = cond_i;
    if (cond_i[C_UNDER] || cond_i[C_OVER]) norm[C_INEXACT] = 1'b1;
  end

  for (genvar i = 0; i < NMASKABLE; i++) begin : g_cond
    assign fire[i]       = valid_i & norm[i] & enable_i[i];
    assign flag_set_o[i] = valid_i & norm[i] & ~enable_i[i];
  end

  assign cause_o = norm;
  assign trap_o  = (|fire) | (valid_i & norm[C_UNIMPL]);
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int CTL_INDEX = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_en_i,
  input  logic [IDX_W-1:0] ctl_wr_idx_i,
  input  logic [31:0]      ctl_wr_data_i,
  input  logic [IDX_W-1:0] ctl_rd_idx_i,
  output logic [31:0]      ctl_rd_data_o,
  input  logic             rpt_valid_i,
  input  logic [5:0]       rpt_cond_i,
  output logic [1:0]       round_mode_o,
  output logic [31:0]      csr_o,
  output logic             trap_o
);
  logic [CSR_W-1:0] csr_q, csr_d, base, wr_val;
  logic             wr_hit, trap_req, trap_q;
  cond_t            cause;
  mask_t            flag_set;

  fpcsr_port #(.IDX_W(IDX_W), .CTL_INDEX(CTL_INDEX)) port_i (
    .wr_en_i  (ctl_wr_en_i),
    .wr_idx_i (ctl_wr_idx_i),
    .wr_data_i(ctl_wr_data_i),
    .rd_idx_i (ctl_rd_idx_i),
    .csr_i    (csr_q),
    .wr_hit_o (wr_hit),
    .wr_val_o (wr_val),
    .rd_data_o(ctl_rd_data_o)
  );

  // software write forms the base, the report lands on top of it
  assign base = wr_hit ? wr_val : csr_q;

  fpcsr_event event_i (
    .valid_i   (rpt_valid_i),
    .cond_i    (rpt_cond_i),
    .enable_i  (base[EN_LSB +: NMASKABLE]),
    .cause_o   (cause),
    .flag_set_o(flag_set),
    .trap_o    (trap_req)
  );

  always_comb begin
    csr_d = base;
    if (rpt_valid_i) begin
      csr_d[CAUSE_LSB +: NCOND]    = cause;
      csr_d[FLAG_LSB +: NMASKABLE] = base[FLAG_LSB +: NMASKABLE] | flag_set;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      csr_q  <= csr_d;
      trap_q <= trap_req;
    end
  end

  assign csr_o        = csr_q;
  assign round_mode_o = csr_q[RM_LSB +: RM_W];
  assign trap_o       = trap_q;

  // R4: reserved positions never hold a one
  a_r4_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_q & ~FIELD_MASK) == '0);

  // R7: range errors carry inexact into the cause field
  a_r7_range_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_i && (rpt_cond_i[C_UNDER] || rpt_cond_i[C_OVER]) |=> csr_q[CAUSE_LSB + C_INEXACT]);

  // R6: unimplemented cause follows the last report
  a_r6_cause_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_i |=> (csr_q[CAUSE_LSB + C_UNIMPL] == $past(rpt_cond_i[C_UNIMPL])));

  // R8: without a software write no flag drops
  a_r8_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> ((csr_q[FLAG_LSB +: NMASKABLE] & $past(csr_q[FLAG_LSB +: NMASKABLE]))
                 == $past(csr_q[FLAG_LSB +: NMASKABLE])));

  // R9: a trap only follows a report
  a_r9_trap_after_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(rpt_valid_i));

  // R10: unimplemented cannot be masked
  a_r10_unimpl_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_i && rpt_cond_i[C_UNIMPL] |=> trap_o);

  // R12: idle cycles keep the word
  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit && !rpt_valid_i |=> $stable(csr_q));
endmodule

// File: tb/fpcsr_unit_tb.sv
`timescale 1ns/1ps
module fpcsr_unit_tb_top;
  localparam logic [31:0] MASK = 32'h0183_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_idx = 5'd31;
  logic [31:0] rd_data;
  logic        rpt_v = 1'b0;
  logic [5:0]  rpt_c = '0;
  logic [1:0]  rmode;
  logic [31:0] csr;
  logic        trap;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_csr = '0;
  logic        m_trap = 1'b0;

  always #2 clk = ~clk;

  fpcsr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_wr_en_i(wr_en), .ctl_wr_idx_i(wr_idx), .ctl_wr_data_i(wr_data),
    .ctl_rd_idx_i(rd_idx), .ctl_rd_data_o(rd_data),
    .rpt_valid_i(rpt_v), .rpt_cond_i(rpt_c),
    .round_mode_o(rmode), .csr_o(csr), .trap_o(trap)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R6 cause field", {26'b0, csr[17:12]}, {26'b0, m_csr[17:12]});
    chk("R8 flag field", {27'b0, csr[6:2]}, {27'b0, m_csr[6:2]});
    chk("R9 trap pulse", {31'b0, trap}, {31'b0, m_trap});
    chk("R11 full word", csr, m_csr);
    chk("R5 rounding mode", {30'b0, rmode}, {30'b0, m_csr[1:0]});
    chk("R2 read index 31", rd_data, m_csr);
  endtask

  // one clock: drive, advance past the edge, update the model from the requirements
  task automatic step(input logic we, input logic [4:0] widx, input logic [31:0] wd,
                      input logic rv, input logic [5:0] rc);
    logic [31:0] b;
    logic [5:0]  c;
    logic        tr;
    wr_en = we; wr_idx = widx; wr_data = wd; rpt_v = rv; rpt_c = rc;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rpt_v = 1'b0; rpt_c = '0;
    b  = (we && widx == 5'd31) ? (wd & MASK) : m_csr;
    tr = 1'b0;
    if (rv) begin
      c = rc;
      if (c[1] || c[2]) c[0] = 1'b1;
      b[17:12] = c;
      b[6:2]   = b[6:2] | (c[4:0] & ~b[11:7]);
      tr       = (|(c[4:0] & b[11:7])) | c[5];
    end
    m_csr  = b;
    m_trap = tr;
    check_all();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    #7;
    // R1 reset state
    chk("R1 word after reset", csr, 32'h0);
    chk("R1 trap after reset", {31'b0, trap}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 word after release", csr, 32'h0);

    // R4 writable positions only
    step(1'b1, 5'd31, 32'hFFFF_FFFF, 1'b0, 6'h0);
    chk("R4 all-ones write", csr, 32'h0183_FFFF);
    rd_idx = 5'd5; #1;
    chk("R2 other index reads zero", rd_data, 32'h0);
    rd_idx = 5'd31; #1;

    // R3 wrong index write ignored
    step(1'b1, 5'd30, 32'h0, 1'b0, 6'h0);
    chk("R3 wrong-index write", csr, 32'h0183_FFFF);
    step(1'b1, 5'd0, 32'h0, 1'b0, 6'h0);
    chk("R3 index zero write", csr, 32'h0183_FFFF);

    // R12 idle holds
    step(1'b0, 5'd31, 32'h0, 1'b0, 6'h0);
    chk("R12 idle hold", csr, 32'h0183_FFFF);

    // main sweep: every enable mask against every condition pattern
    for (int en = 0; en < 32; en++) begin
      step(1'b1, 5'd31, (32'(en) << 7) | 32'(en & 3), 1'b0, 6'h0);
      for (int c = 0; c < 64; c++) step(1'b0, 5'd31, 32'h0, 1'b1, 6'(c));
      step(1'b0, 5'd31, 32'h0, 1'b0, 6'h0);
      chk("R12 hold after sweep", csr, m_csr);
    end

    // R7 underflow alone under a clear mask: inexact cause and flag
    step(1'b1, 5'd31, 32'h0, 1'b0, 6'h0);
    step(1'b0, 5'd31, 32'h0, 1'b1, 6'h02);
    chk("R7 underflow forces inexact", csr, 32'h0000_300C);

    // R10 unimplemented under a clear mask still traps, no flag change
    step(1'b1, 5'd31, 32'h0, 1'b0, 6'h0);
    step(1'b0, 5'd31, 32'h0, 1'b1, 6'h20);
    chk("R10 unimplemented trap", {31'b0, trap}, 32'h1);
    chk("R10 unimplemented no flag", csr, 32'h0002_0000);
    step(1'b0, 5'd31, 32'h0, 1'b0, 6'h0);
    chk("R9 trap lasts one cycle", {31'b0, trap}, 32'h0);

    // R11 write and report in one cycle
    step(1'b1, 5'd31, 32'h0000_0002, 1'b1, 6'h10);
    chk("R11 disabled invalid flagged", csr, 32'h0001_0042);
    step(1'b1, 5'd31, 32'h0000_0800, 1'b1, 6'h10);
    chk("R11 written enable traps", {31'b0, trap}, 32'h1);
    chk("R11 written enable word", csr, 32'h0001_0800);

    // R8 software clears a flag
    step(1'b1, 5'd31, 32'h0, 1'b1, 6'h01);
    step(1'b1, 5'd31, 32'h0, 1'b0, 6'h0);
    chk("R8 software clear", csr, 32'h0);

    finish_run();
  end
endmodule